// File: doc/BRIEF.md
# Mode-Controlled Timer Counter

The block is an up-counter whose behaviour is set by an 8-bit control register. A 2-bit mode field in that register picks one of four modes. Stop forces the count to zero. Free-run counts on every prescaler tick. Edge-restart clears the count when a selected edge arrives on an asynchronous input pin. Compare-restart returns the count to zero when it reaches a compare value. The same register holds a sticky overflow flag. Hardware sets the flag and software clears it by writing zero.

Software reaches the register through a plain bus. That bus takes full byte writes and single-bit writes. A separate 2-bit input chooses which edge of the trigger pin counts. The prescaler that makes the tick is outside the block, and so is the logic that makes the compare value. The counter width is a parameter and defaults to 16 bits.

Top module: `tmr_mode_timer`

## Requirements
- R1: After a synchronous reset, `reg_rdata` reads 8'h00, `count` is 0 and `match_pulse` is low.
- R2: While the mode field is 2'b00, `count` is 0 from the next clock on, whatever `tick` does.
- R3: In mode 2'b01, each clock with `tick` high adds one to `count`, and the count wraps from all-ones to 0. A clock with `tick` low leaves `count` unchanged.
- R4: In mode 2'b10, a valid edge on `ext_pin` clears `count` to 0 whatever `tick` does. The pin passes through two synchronizer flops. A pin level first sampled at clock edge k therefore clears the counter at edge k+2. The `edge_sel` encoding is 00 falling, 01 rising, 10 none, 11 both.
- R5: In mode 2'b10, a pin change that `edge_sel` does not select has no effect, and the counter keeps counting ticks.
- R6: In mode 2'b11, a tick while `count` equals `cmp_val` loads 0 instead of incrementing. `match_pulse` is high for exactly the one clock in which the reloaded 0 is first visible. Otherwise a tick increments the count.
- R7: The overflow flag (bit 0) is set when a tick moves the counter from all-ones to 0. This includes a compare reload when `cmp_val` is all-ones. An edge clear in mode 2'b10 does not set the flag.
- R8: The overflow flag stays set until software writes 0 to bit 0. Writing 1 to it does nothing. If a hardware set and a software clear fall in the same clock, the flag ends up set.
- R9: The readback is {4'b0000, mode[1:0], 1'b0, overflow}. A byte write loads the mode from bits 3:2. The value written to bits 7:4 and bit 1 has no effect.
- R10: A bit write with `bit_idx` 2 or 3 sets that mode bit to `bit_val`. With `bit_idx` 0 and `bit_val` 0, it clears the overflow flag. Any other index has no effect. When a byte write and a bit write happen in the same clock, the byte write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| ext_pin | input | 1 | Asynchronous restart trigger |
| edge_sel | input | 2 | Valid-edge choice for `ext_pin` |
| cmp_val | input | CNT_W | Compare value for mode 2'b11 |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| reg_rdata | output | 8 | Control register readback |
| count | output | CNT_W | Counter value |
| match_pulse | output | 1 | One-clock compare reload indication |

## Verification
The bench builds the block with `CNT_W` = 4, so the counter wraps every sixteen ticks. That makes it cheap to sweep wraparound, the set-versus-clear collision and compare values from 0 up to all-ones, the all-ones case included. It also runs all four edge-select codes against both rising and falling pin changes, with the tick held low so that only the edge can clear the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W    = 8;
    localparam int MODE_LSB = 2;
    localparam int OVF_BIT  = 0;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_FREE = 2'b01,
        MODE_EXT  = 2'b10,
        MODE_CMP  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      ovf;
    } ctrl_s;

    function automatic logic edge_valid(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_FALL: return fall;
            EDGE_RISE: return rise;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_s c);
        logic [REG_W-1:0] r;
        r = '0;
        r[MODE_LSB +: 2] = c.mode;
        r[OVF_BIT]       = c.ovf;
        return r;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      edge_hit
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               rise;
    logic               fall;

    genvar g;
    generate
        for (g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        rise     = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
        fall     = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
        edge_hit = edge_valid(sel, rise, fall);
    end

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             bit_wr,
    input  logic [2:0]       bit_idx,
    input  logic             bit_val,
    input  logic             ovf_evt,
    output ctrl_s            ctrl
);
    localparam logic [2:0] IDX_OVF  = 3'(OVF_BIT);
    localparam logic [2:0] IDX_MLO  = 3'(MODE_LSB);
    localparam logic [2:0] IDX_MHI  = 3'(MODE_LSB + 1);

    logic [1:0] mode_nxt;
    logic       sw_clr;

    always_comb begin
        mode_nxt = ctrl.mode;
        sw_clr   = 1'b0;
        if (reg_wr) begin
            mode_nxt = reg_wdata[MODE_LSB +: 2];
            sw_clr   = ~reg_wdata[OVF_BIT];
        end else if (bit_wr) begin
            if (bit_idx == IDX_MLO) mode_nxt[0] = bit_val;
            if (bit_idx == IDX_MHI) mode_nxt[1] = bit_val;
            if (bit_idx == IDX_OVF) sw_clr      = ~bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.mode <= MODE_STOP;
            ctrl.ovf  <= 1'b0;
        end else begin
            ctrl.mode <= tmr_mode_e'(mode_nxt);
            ctrl.ovf  <= ovf_evt | (ctrl.ovf & ~sw_clr);
        end
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_mode_e        mode,
    input  logic             tick,
    input  logic             ext_edge,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             match_pulse,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_nxt;
    logic             match_now;
    logic             at_max;

    assign at_max = (count == CNT_MAX);

    always_comb begin
        count_nxt = count;
        match_now = 1'b0;
        ovf_evt   = 1'b0;
        case (mode)
            MODE_STOP: count_nxt = '0;
            MODE_FREE: begin
                if (tick) begin
                    count_nxt = count + 1'b1;
                    ovf_evt   = at_max;
                end
            end
            MODE_EXT: begin
                if (ext_edge) begin
                    count_nxt = '0;
                end else if (tick) begin
                    count_nxt = count + 1'b1;
                    ovf_evt   = at_max;
                end
            end
            MODE_CMP: begin
                if (tick) begin
                    ovf_evt = at_max;
                    if (count == cmp_val) begin
                        count_nxt = '0;
                        match_now = 1'b1;
                    end else begin
                        count_nxt = count + 1'b1;
                    end
                end
            end
            default: count_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count       <= '0;
            match_pulse <= 1'b0;
        end else begin
            count       <= count_nxt;
            match_pulse <= match_now;
        end
    end

endmodule

// File: rtl/tmr_mode_timer.sv
module tmr_mode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ext_pin,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    input  logic             bit_wr,
    input  logic [2:0]       bit_idx,
    input  logic             bit_val,
    output logic [7:0]       reg_rdata,
    output logic [CNT_W-1:0] count,
    output logic             match_pulse
);
    ctrl_s ctrl;
    logic  ext_edge;
    logic  ovf_evt;

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .sel      (edge_sel_e'(edge_sel)),
        .edge_hit (ext_edge)
    );

    tmr_ctrl_reg reg_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .bit_wr    (bit_wr),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .ovf_evt   (ovf_evt),
        .ctrl      (ctrl)
    );

    tmr_count_core #(.CNT_W(CNT_W)) core_i (
        .clk         (clk),
        .rst         (rst),
        .mode        (ctrl.mode),
        .tick        (tick),
        .ext_edge    (ext_edge),
        .cmp_val     (cmp_val),
        .count       (count),
        .match_pulse (match_pulse),
        .ovf_evt     (ovf_evt)
    );

    assign reg_rdata = pack_ctrl(ctrl);

endmodule

// File: rtl/tmr_mode_timer_chk.sv
module tmr_mode_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] cmp_val,
    input logic             reg_wr,
    input logic             bit_wr,
    input logic [7:0]       reg_rdata,
    input logic [CNT_W-1:0] count,
    input logic             match_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[3:2] == 2'b00 |=> count == '0); // R2

    AST_FREE_INC: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[3:2] == 2'b01 && tick) |=> count == CNT_W'($past(count) + 1'b1)); // R3

    AST_FREE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[3:2] == 2'b01 && !tick) |=> $stable(count)); // R3

    AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[3:2] == 2'b11 && tick && count == cmp_val) |=> (count == '0 && match_pulse)); // R6

    AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> count == '0); // R6

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[3:2] == 2'b01 && tick && count == CNT_MAX) |=> reg_rdata[0]); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && !reg_wr && !bit_wr) |=> reg_rdata[0]); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7:4] == 4'h0 && reg_rdata[1] == 1'b0)); // R9

endmodule

bind tmr_mode_timer tmr_mode_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .cmp_val     (cmp_val),
    .reg_wr      (reg_wr),
    .bit_wr      (bit_wr),
    .reg_rdata   (reg_rdata),
    .count       (count),
    .match_pulse (match_pulse)
);

// File: tb/tmr_mode_timer_tb_top.sv
module tmr_mode_timer_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         ext_pin = 1'b0;
    logic [1:0]   edge_sel = 2'b01;
    logic [W-1:0] cmp_val = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_wdata = '0;
    logic         bit_wr = 1'b0;
    logic [2:0]   bit_idx = '0;
    logic         bit_val = 1'b0;
    logic [7:0]   reg_rdata;
    logic [W-1:0] count;
    logic         match_pulse;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    int  exp_cnt;
    bit  exp_ovf;
    bit  exp_match;

    tmr_mode_timer #(.CNT_W(W)) dut_i (
        .clk (clk), .rst (rst), .tick (tick), .ext_pin (ext_pin),
        .edge_sel (edge_sel), .cmp_val (cmp_val), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .bit_wr (bit_wr), .bit_idx (bit_idx),
        .bit_val (bit_val), .reg_rdata (reg_rdata), .count (count),
        .match_pulse (match_pulse)
    );

    always #5 clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic wr_bit(input int idx, input logic v);
        bit_wr = 1'b1; bit_idx = 3'(idx); bit_val = v;
        cyc();
        bit_wr = 1'b0;
    endtask

    task automatic go_stop();
        tick = 1'b0;
        wr_byte(8'h00);
        cyc();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 count", count, 0);
        chk("R1 match", match_pulse, 0);

        // R2: stop mode holds zero even with ticks
        tick = 1'b1;
        repeat (4) begin cyc(); chk("R2 stop count", count, 0); end

        // R3/R7: free-run sweep with irregular ticks
        tick = 1'b0;
        wr_byte(8'h04);
        exp_cnt = 0; exp_ovf = 0;
        for (int i = 0; i < 40; i++) begin
            tick = (i % 3 != 0);
            cyc();
            if (tick) begin
                if (exp_cnt == 15) exp_ovf = 1;
                exp_cnt = (exp_cnt + 1) % 16;
            end
            chk("R3 free count", count, exp_cnt);
            chk("R7 ovf flag", reg_rdata[0], exp_ovf);
        end
        tick = 1'b0;
        chk("R9 readback", reg_rdata, 8'h05);

        // R8: writing 1 keeps flag, writing 0 clears
        wr_byte(8'h05);
        chk("R8 write1 no effect", reg_rdata, 8'h05);
        wr_byte(8'h04);
        chk("R8 write0 clears", reg_rdata, 8'h04);

        // R8: set wins over simultaneous clear
        tick = 1'b1;
        while (exp_cnt != 15) begin cyc(); exp_cnt++; end
        chk("R3 reach max", count, 15);
        reg_wr = 1'b1; reg_wdata = 8'h04;
        cyc();
        reg_wr = 1'b0; tick = 1'b0;
        chk("R3 wrap", count, 0);
        chk("R8 set wins", reg_rdata, 8'h05);

        // R9: reserved bits ignored on byte write
        wr_byte(8'hF7);
        chk("R9 reserved ignored", reg_rdata, 8'h05);

        // R2: going to stop clears count
        tick = 1'b1; cyc(); cyc();
        go_stop();
        chk("R2 stop clears", count, 0);

        // R4/R5: edge-select sweep, tick low while edge propagates
        for (int es = 0; es < 4; es++) begin
            for (int rise = 0; rise < 2; rise++) begin
                bit valid;
                valid = (es == 3) || (es == 1 && rise == 1) || (es == 0 && rise == 0);
                go_stop();
                ext_pin = (rise == 1) ? 1'b0 : 1'b1;
                edge_sel = 2'(es);
                repeat (4) cyc();
                wr_byte(8'h08);
                tick = 1'b1;
                repeat (5) cyc();
                chk("R5 ext counts", count, 5);
                tick = 1'b0;
                ext_pin = ~ext_pin;
                cyc(); cyc();
                chk("R4 sync delay", count, 5);
                cyc();
                chk(valid ? "R4 edge clears" : "R5 edge ignored", count, valid ? 0 : 5);
                tick = 1'b1;
                cyc();
                chk("R4 resume", count, valid ? 1 : 6);
            end
        end

        // R6/R7: compare-restart sweep
        for (int c = 0; c < 16; c++) begin
            go_stop();
            cmp_val = 4'(c);
            tick = 1'b1;
            wr_byte(8'h0C);
            exp_cnt = 0; exp_ovf = 0;
            for (int i = 0; i < 2 * (c + 1) + 3; i++) begin
                cyc();
                exp_match = 0;
                if (exp_cnt == c) begin
                    if (c == 15) exp_ovf = 1;
                    exp_cnt = 0; exp_match = 1;
                end else begin
                    exp_cnt++;
                end
                chk("R6 cmp count", count, exp_cnt);
                chk("R6 match pulse", match_pulse, exp_match);
            end
            chk("R7 cmp ovf", reg_rdata[0], exp_ovf);
        end

        // R10: single-bit writes
        go_stop();
        wr_bit(2, 1'b1);
        chk("R10 bit2", reg_rdata, 8'h04);
        wr_bit(3, 1'b1);
        chk("R10 bit3", reg_rdata, 8'h0C);
        wr_bit(5, 1'b1);
        chk("R10 idx5 ignored", reg_rdata, 8'h0C);
        wr_bit(1, 1'b1);
        chk("R10 idx1 ignored", reg_rdata, 8'h0C);
        wr_bit(3, 1'b0);
        tick = 1'b1;
        repeat (17) cyc();
        tick = 1'b0;
        chk("R7 free ovf", reg_rdata, 8'h05);
        wr_bit(0, 1'b1);
        chk("R10 bit0 write1", reg_rdata, 8'h05);
        wr_bit(0, 1'b0);
        chk("R10 bit0 clear", reg_rdata, 8'h04);
        reg_wr = 1'b1; reg_wdata = 8'h00;
        bit_wr = 1'b1; bit_idx = 3'd3; bit_val = 1'b1;
        cyc();
        reg_wr = 1'b0; bit_wr = 1'b0;
        chk("R10 byte priority", reg_rdata, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule